// File: doc/BRIEF.md
# Reset Cause Vector Register

This block records why the chip last restarted or woke up. Sixteen cause slots each hold a sticky flag, and each flag is set by a one-cycle pulse from the logic that detects that event. The slots fall into three classes. The brownout-grade causes are at the top of the order. Power-on-grade supply causes come next. Soft-reset causes such as watchdog expiry and key violations are at the bottom. The block does not generate any reset and does not watch the supplies. It only remembers and reports.

Software reads one vector register. The value on that register is an even code that names the most urgent cause still pending, and zero when nothing is pending. Each read returns the code on the register and clears only the flag it reported. A loop that reads until it gets zero therefore visits every recorded cause exactly once, from the most urgent to the least urgent. A global clear input wipes every flag at once.

Top module: `rst_cause_vec`

## Requirements
- R1: After reset, and whenever no flag is set, `vecOut` is 0x00.
- R2: With flags pending, `vecOut` equals 2*(k+1), where k is the lowest-numbered set slot. Slot 0 is the most urgent. The codes are: brownout class slots 0–4 (0x02 brownout, 0x04 reset pin/NMI, 0x06 soft brownout request, 0x08 low-power wakeup, 0x0A security violation); power-on class slots 5–9 (0x0C low supply supervisor, 0x0E high supply supervisor, 0x10 low monitor overvoltage, 0x12 high monitor overvoltage, 0x14 soft power-on request); soft-reset class slots 10–15 (0x16 watchdog timeout, 0x18 watchdog key violation, 0x1A flash key violation, 0x1C reserved, 0x1E peripheral-area fetch, 0x20 power-manager key violation).
- R3: A cycle with `rdStb` high returns the current `vecOut` code and clears the flag of that slot at the clock edge.
- R4: A read leaves every other flag unchanged, so reads repeated until zero return the pending codes in ascending order.
- R5: A one-cycle pulse on `causeEvt[i]` sets flag i. The flag then stays set until a read reports it or `clearAll` is asserted.
- R6: An event that arrives in the same cycle as a read is not lost, even when it targets the slot being cleared. In that case the set wins.
- R7: `clearAll` high clears every flag at the next edge and overrides events in the same cycle.
- R8: The reserved slot 13 (code 0x1C) is never set, and a pulse on it has no effect. No code above 0x20 is ever produced.
- R9: `vecOut` is combinational from the flags, so it changes in the cycle after the edge that changes a flag.
- R10: A read while nothing is pending returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all flags |
| clearAll | input | 1 | Synchronous clear of every flag |
| causeEvt | input | 16 | One pulse line per cause slot |
| rdStb | input | 1 | Bus read strobe for the vector register |
| vecOut | output | 16 | Encoded code of the most urgent pending cause |

## Verification
The bench goes after five corner cases, and each one shows a typical fault.

- **All flags set, then drained:** a wrong priority encoder returns the codes out of order. A design that clears more than the reported flag skips codes.
- **Read in the same cycle as an event:** an event on the slot being cleared must survive. A design where the clear wins loses that cause.
- **Clear-all in the same cycle as events:** a design that lets events win leaves stale flags behind.
- **Reserved slot and empty reads:** pulses on the reserved slot and reads of an empty register must leave the output at zero. A design that accepts the reserved slot reports 0x1C.
- **Long pseudo-random mix of pulses, reads and clears:** this exposes flags that drop without a read.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic clrAll;  // wipe every flag
    logic popTop;  // clear the flag currently reported
  } rcvStrobe_t;
endpackage

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
  import rcv_pkg::*;
(
  input  logic       rdStb,
  input  logic       clearAll,
  input  logic       anyPend,
  output rcvStrobe_t strb
);
  always_comb begin
    strb        = '0;
    strb.clrAll = clearAll;
    // a read only pops when something is pending and no global clear competes
    strb.popTop = rdStb && anyPend && !clearAll;
  end
endmodule

// File: rtl/rcv_dp.sv
module rcv_dp
  import rcv_pkg::*;
#(
  parameter int NUM_CAUSES = 16,
  parameter int VEC_W      = 16,
  parameter int RSV_IDX    = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rcvStrobe_t            strb,
  input  logic [NUM_CAUSES-1:0] causeEvt,
  output logic [NUM_CAUSES-1:0] flagsQ,
  output logic                  anyPend,
  output logic [VEC_W-1:0]      vecOut
);
  logic [NUM_CAUSES-1:0] acceptMask;
  logic [NUM_CAUSES-1:0] topOneHot;
  logic [NUM_CAUSES-1:0] popMask;
  logic [NUM_CAUSES-1:0] setMask;

  // slots that may ever latch; the reserved one is tied off
  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_accept
    assign acceptMask[g] = (g != RSV_IDX);
  end

  // fixed-priority pick: lowest slot index wins
  always_comb begin
    topOneHot = '0;
    vecOut    = '0;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (flagsQ[i]) begin
        topOneHot    = '0;
        topOneHot[i] = 1'b1;
        vecOut       = VEC_W'(2 * (i + 1));
      end
    end
  end

  assign anyPend = |flagsQ;
  assign popMask = strb.popTop ? topOneHot : '0;
  assign setMask = causeEvt & acceptMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (strb.clrAll) begin
      flagsQ <= '0;
    end else begin
      // new events are OR-ed after the pop so a same-slot set survives
      flagsQ <= (flagsQ & ~popMask) | setMask;
    end
  end
endmodule

// File: rtl/rst_cause_vec.sv
module rst_cause_vec
  import rcv_pkg::*;
#(
  parameter int NUM_CAUSES = 16,
  parameter int VEC_W      = 16,
  parameter int RSV_IDX    = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clearAll,
  input  logic [NUM_CAUSES-1:0] causeEvt,
  input  logic                  rdStb,
  output logic [VEC_W-1:0]      vecOut
);
  rcvStrobe_t            strb;
  logic                  anyPend;
  logic [NUM_CAUSES-1:0] flagsQ;

  rcv_ctrl u_ctrl (
    .rdStb   (rdStb),
    .clearAll(clearAll),
    .anyPend (anyPend),
    .strb    (strb)
  );

  rcv_dp #(
    .NUM_CAUSES(NUM_CAUSES),
    .VEC_W     (VEC_W),
    .RSV_IDX   (RSV_IDX)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .causeEvt(causeEvt),
    .flagsQ  (flagsQ),
    .anyPend (anyPend),
    .vecOut  (vecOut)
  );
endmodule

// File: rtl/rcv_chk.sv
module rcv_chk #(
  parameter int NUM_CAUSES = 16,
  parameter int VEC_W      = 16,
  parameter int RSV_IDX    = 13
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clearAll,
  input logic [NUM_CAUSES-1:0] causeEvt,
  input logic                  rdStb,
  input logic [VEC_W-1:0]      vecOut,
  input logic [NUM_CAUSES-1:0] flagsQ
);
  localparam logic [NUM_CAUSES-1:0] ONE = NUM_CAUSES'(1);

  // lowest set bit, found arithmetically rather than by scanning
  logic [NUM_CAUSES-1:0] lowBit;
  assign lowBit = flagsQ & (~flagsQ + ONE);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ == '0) |-> (vecOut == '0));

  a_r8_code_range: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut[0] == 1'b0) && (vecOut <= VEC_W'(2 * NUM_CAUSES)));

  a_r8_reserved_never: assert property (@(posedge clk) disable iff (!rstN)
    !flagsQ[RSV_IDX]);

  a_r4_others_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !clearAll) |=> ((($past(flagsQ) & ~$past(lowBit)) & ~flagsQ) == '0));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (flagsQ == '0));

  a_r9_stable_out: assert property (@(posedge clk) disable iff (!rstN)
    $stable(flagsQ) |-> $stable(vecOut));

  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !clearAll && flagsQ == '0 && causeEvt == '0) |=> (flagsQ == '0));

  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_slot
    if (i != RSV_IDX) begin : g_live
      a_r3_pop_reported: assert property (@(posedge clk) disable iff (!rstN)
        (rdStb && !clearAll && !causeEvt[i] && vecOut == VEC_W'(2 * (i + 1))) |=> !flagsQ[i]);

      a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
        $fell(flagsQ[i]) |-> $past(rdStb || clearAll));

      a_r6_event_sets: assert property (@(posedge clk) disable iff (!rstN)
        (causeEvt[i] && !clearAll) |=> flagsQ[i]);
    end
  end
endmodule

bind rst_cause_vec rcv_chk #(
  .NUM_CAUSES(NUM_CAUSES),
  .VEC_W     (VEC_W),
  .RSV_IDX   (RSV_IDX)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .clearAll(clearAll),
  .causeEvt(causeEvt),
  .rdStb   (rdStb),
  .vecOut  (vecOut),
  .flagsQ  (flagsQ)
);

// File: tb/sim_rst_cause_vec.sv
`timescale 1ns/1ps
module sim_rst_cause_vec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearAll = 1'b0;
  logic [15:0] causeEvt = '0;
  logic        rdStb = 1'b0;
  logic [15:0] vecOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  bit [15:0] model;  // behavioural flag set

  always #2.5 clk = ~clk;

  rst_cause_vec u0 (
    .clk(clk), .rstN(rstN), .clearAll(clearAll),
    .causeEvt(causeEvt), .rdStb(rdStb), .vecOut(vecOut)
  );

  function automatic int refCode();
    for (int i = 0; i < 16; i++)
      if (model[i]) return 2 * (i + 1);
    return 0;
  endfunction

  task automatic check(int act, int exp, string req);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: vecOut=0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive one cycle, compare the register before the edge, update the model after it
  task automatic step(logic [15:0] ev, bit rd, bit clr, string req);
    causeEvt = ev; rdStb = rd; clearAll = clr;
    #1;
    check(int'(vecOut), refCode(), req);
    @(posedge clk);
    if (clr) model = '0;
    else begin
      if (rd && refCode() != 0) model[refCode() / 2 - 1] = 1'b0;
      model = model | (ev & ~16'h2000);  // slot 13 never latches (R8)
    end
    @(negedge clk);
    causeEvt = '0; rdStb = 1'b0; clearAll = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(int'(vecOut), 0, "R1 reset");

    // R2/R3: each slot alone, read it, then read empty (R10)
    for (int i = 0; i < 16; i++) begin
      step(16'(1) << i, 0, 0, "R5 set");
      step('0, 1, 0, "R2 R3 single read");
      step('0, 1, 0, "R10 empty read");
    end

    // R4: all slots pending, drain in ascending code order
    step(16'hFFFF, 0, 0, "R8 set all");
    for (int k = 0; k < 16; k++) step('0, 1, 0, "R4 drain");

    // R5: stickiness over idle cycles
    step(16'h0400, 0, 0, "R5 set");
    for (int k = 0; k < 10; k++) step('0, 0, 0, "R5 sticky");
    step('0, 1, 0, "R3 pop");

    // R6: event on another slot during a read, and on the slot being read
    step(16'h0008, 0, 0, "R6 setup");
    step(16'h0001, 1, 0, "R6 other slot");
    step('0, 0, 0, "R6 other kept");
    step(16'h0001, 1, 0, "R6 same slot");
    step('0, 0, 0, "R6 same kept");
    step('0, 1, 0, "R6 drain");
    step('0, 1, 0, "R6 drain");

    // R7: clear overrides simultaneous events and reads
    step(16'h8421, 0, 0, "R7 setup");
    step(16'h0102, 1, 1, "R7 clear");
    step('0, 0, 0, "R7 cleared");

    // R8: reserved slot pulse has no effect
    step(16'h2000, 0, 0, "R8 reserved");
    step('0, 0, 0, "R8 reserved");
    step('0, 1, 0, "R8 reserved read");

    // mixed pseudo-random traffic, compared every cycle (R9)
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr & {lfsr[7:0], lfsr[15:8]} & 16'h5AA5 | (lfsr[3:0] == 4'h5 ? 16'h2000 : 16'h0),
             lfsr[0] ^ lfsr[9], lfsr[15:11] == 5'h0, "R9 mixed");
      end
    end
    finishRun();
  end
endmodule